// File: doc/BRIEF.md
# I2C Master Byte and Condition Engine

This block drives the clock and data wires of a two-wire serial bus as the only master on that bus. Both wires are open-drain. A logical 1 on a wire means the engine releases it and the pull-up raises it. A logical 0 means the engine pulls the wire low. A sequencer sends the engine one command at a time over a valid/ready handshake. The five commands are: start condition, repeated start, stop condition, write a byte and check the acknowledge, and read a byte and return a chosen acknowledge bit. When a command finishes, the engine raises a one-cycle done pulse. The pulse carries the received byte and the acknowledge-error flag.

Every change of the wires is a phase. A phase lasts a fixed number of pulses of a free-running tick enable. The phase length comes from a speed-grade input, which the engine captures when it accepts the command. The incoming data wire passes through a two-flop synchroniser before the engine samples it. For that reason the tick period must be longer than two clock cycles.

Top module: `i2c_byte_engine`

## Requirements
- R1: During and after reset, both wires are released (scl_oe_o = 0, sda_oe_o = 0), cmd_ready_o is 1 and done_o is 0.
- R2: Every phase lasts exactly N tick pulses. N is TICKS_SLOW (10) for speed_i = 0, TICKS_FAST (3) for speed_i = 1, and TICKS_FPLUS (1) for speed_i = 2 or 3. speed_i is captured when the command is accepted, so a later change of speed_i does not alter the running command.
- R3: Command code 0 (start) takes 3 phases, with (clock, data) states (1,1), (1,0) and (0,0). It leaves both wires driven low.
- R4: Command code 1 (repeated start) takes 4 phases: (0,1), (1,1), (1,0) and (0,0). It creates exactly one start condition and no stop condition.
- R5: Command code 2 (stop) takes 3 phases: (0,0), (1,0) and (1,1). It ends with both wires released and produces one stop condition.
- R6: Command code 3 (write) shifts wr_data_i out most significant bit first. Each bit takes three phases: data set with clock low, clock high, clock low. The data wire never changes while the clock is high.
- R7: After the 8 data bits, a write runs three more phases: (0,1), then (1,1) with the data wire sampled at the end of that phase, then (0,1). The command takes 27 phases in all. At done, ack_err_o is 0 if the sample was low and 1 if it was high.
- R8: Command code 4 (read) takes one release phase (0,1). It then gives 8 clock pulses of two phases each, (1,1) and (0,1). At the end of each high phase it samples the data wire and shifts it in as byte = byte*2 + bit. rd_data_o holds the byte at done.
- R9: After the 8 received bits, a read clocks out rd_ack_i (captured at accept; 0 acknowledges, 1 declines) in three phases: (0,a), (1,a), (0,a). The read takes 20 phases in all.
- R10: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both 1. cmd_ready_o stays 0 until the last phase ends. done_o is then 1 for exactly one cycle. ack_err_o is 0 at the done of any command other than write.
- R11: Command codes 5, 6 and 7 are reserved. Each is accepted and completed, with done_o in the cycle after acceptance. No tick is consumed and the wires do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Free-running time-base enable for phase counting |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle and able to accept a command |
| cmd_i | input | 3 | Command code (0 start, 1 repeated start, 2 stop, 3 write, 4 read) |
| speed_i | input | 2 | Speed grade selecting the phase length |
| wr_data_i | input | DATA_W | Byte to transmit for a write |
| rd_ack_i | input | 1 | Acknowledge bit sent after a read (0 acknowledge) |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | DATA_W | Received byte, valid at done of a read |
| ack_err_o | output | 1 | Acknowledge missing, valid at done of a write |
| scl_oe_o | output | 1 | Pull the clock wire low when 1 |
| sda_oe_o | output | 1 | Pull the data wire low when 1 |
| sda_i | input | 1 | Level of the data wire |

## Verification
A wrong phase counter or a wrong captured speed changes the number of ticks between acceptance and done. It also changes the width of each clock-high pulse. Both of these show within the first command. A wrong bit counter or sub-phase state changes the number of clock pulses, so the byte a modelled slave receives, the position of its acknowledge, or the byte returned on rd_data_o is wrong. This shows at the done of the same command. A wrong condition step shows up as a missing or extra start or stop edge, or as the wrong wire levels left at done. The sweep runs over all four speed codes and over several data and acknowledge patterns.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COND,
        ST_WBIT,
        ST_WACK,
        ST_RREL,
        ST_RBIT,
        ST_RACK
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    localparam lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

    // Phase length in ticks for a speed code.
    function automatic int phase_len(input logic [1:0] code, input int slow,
                                     input int fast, input int fplus);
        case (code)
            2'd0:    return slow;
            2'd1:    return fast;
            default: return fplus;
        endcase
    endfunction

    // Wire state of one step of a bus condition.
    // Start-type: (0,1) (1,1) (1,0) (0,0); a plain start begins at step 1.
    // Stop: (0,0) (1,0) (1,1).
    function automatic lines_t cond_line(input logic is_stop, input logic [1:0] step);
        lines_t l;
        if (is_stop) begin
            l.scl = (step != 2'd0);
            l.sda = (step >= 2'd2);
        end else begin
            l.scl = (step == 2'd1) || (step == 2'd2);
            l.sda = (step <= 2'd1);
        end
        return l;
    endfunction

    function automatic logic [1:0] cond_last(input logic is_stop);
        return is_stop ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '1;
                else     sr_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '1;
                else     sr_q <= {sr_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             busy_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             phase_end_o
);
    logic [CNT_W-1:0] cnt_q;

    assign phase_end_o = busy_i && tick_i && (cnt_q == len_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear_i)         cnt_q <= '0;
        else if (phase_end_o)       cnt_q <= '0;
        else if (busy_i && tick_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (cnt_q < len_i));
endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
    import i2c_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int TICKS_SLOW  = 10,
    parameter int TICKS_FAST  = 3,
    parameter int TICKS_FPLUS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [2:0]        cmd_i,
    input  logic [1:0]        speed_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_ack_i,
    input  logic              sda_s_i,
    input  logic              phase_end_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  len_o,
    output lines_t            lines_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ack_err_o,
    output logic              done_o
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    seq_state_e        state_q;
    logic [1:0]        sub_q;
    logic [BIT_W-1:0]  bit_q;
    logic              stop_q;
    logic [DATA_W-1:0] wsh_q;
    logic [DATA_W-1:0] rsh_q;
    logic              ackb_q;
    logic              err_q;
    logic              done_q;
    logic [CNT_W-1:0]  len_q;
    lines_t            line_q;
    logic              accept;
    logic              last_bit;

    assign accept   = cmd_valid_i && (state_q == ST_IDLE);
    assign last_bit = (bit_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            bit_q   <= '0;
            stop_q  <= 1'b0;
            wsh_q   <= '0;
            rsh_q   <= '0;
            ackb_q  <= 1'b1;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            len_q   <= CNT_W'(TICKS_SLOW);
            line_q  <= LINES_IDLE;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                len_q  <= CNT_W'(phase_len(speed_i, TICKS_SLOW, TICKS_FAST, TICKS_FPLUS));
                err_q  <= 1'b0;
                ackb_q <= rd_ack_i;
                sub_q  <= 2'd0;
                bit_q  <= BIT_W'(DATA_W - 1);
                case (op_e'(cmd_i))
                    OP_START: begin
                        state_q <= ST_COND;
                        stop_q  <= 1'b0;
                        sub_q   <= 2'd1;
                        line_q  <= cond_line(1'b0, 2'd1);
                    end
                    OP_RESTART: begin
                        state_q <= ST_COND;
                        stop_q  <= 1'b0;
                        line_q  <= cond_line(1'b0, 2'd0);
                    end
                    OP_STOP: begin
                        state_q <= ST_COND;
                        stop_q  <= 1'b1;
                        line_q  <= cond_line(1'b1, 2'd0);
                    end
                    OP_WRITE: begin
                        state_q    <= ST_WBIT;
                        wsh_q      <= wr_data_i;
                        line_q.scl <= 1'b0;
                        line_q.sda <= wr_data_i[DATA_W-1];
                    end
                    OP_READ: begin
                        state_q <= ST_RREL;
                        line_q  <= '{scl: 1'b0, sda: 1'b1};
                    end
                    default: done_q <= 1'b1;
                endcase
            end else if (phase_end_i) begin
                case (state_q)
                    ST_COND: begin
                        if (sub_q == cond_last(stop_q)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            sub_q  <= sub_q + 2'd1;
                            line_q <= cond_line(stop_q, sub_q + 2'd1);
                        end
                    end
                    ST_WBIT: begin
                        case (sub_q)
                            2'd0: begin
                                sub_q      <= 2'd1;
                                line_q.scl <= 1'b1;
                            end
                            2'd1: begin
                                sub_q      <= 2'd2;
                                line_q.scl <= 1'b0;
                            end
                            default: begin
                                sub_q <= 2'd0;
                                if (last_bit) begin
                                    state_q <= ST_WACK;
                                    line_q  <= '{scl: 1'b0, sda: 1'b1};
                                end else begin
                                    bit_q      <= bit_q - BIT_W'(1);
                                    wsh_q      <= wsh_q << 1;
                                    line_q.sda <= wsh_q[DATA_W-2];
                                end
                            end
                        endcase
                    end
                    ST_WACK: begin
                        case (sub_q)
                            2'd0: begin
                                sub_q  <= 2'd1;
                                line_q <= '{scl: 1'b1, sda: 1'b1};
                            end
                            2'd1: begin
                                sub_q  <= 2'd2;
                                err_q  <= sda_s_i;
                                line_q <= '{scl: 1'b0, sda: 1'b1};
                            end
                            default: begin
                                sub_q   <= 2'd0;
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        endcase
                    end
                    ST_RREL: begin
                        state_q <= ST_RBIT;
                        sub_q   <= 2'd0;
                        line_q  <= '{scl: 1'b1, sda: 1'b1};
                    end
                    ST_RBIT: begin
                        if (sub_q == 2'd0) begin
                            sub_q  <= 2'd1;
                            rsh_q  <= {rsh_q[DATA_W-2:0], sda_s_i};
                            line_q <= '{scl: 1'b0, sda: 1'b1};
                        end else begin
                            sub_q <= 2'd0;
                            if (last_bit) begin
                                state_q <= ST_RACK;
                                line_q  <= '{scl: 1'b0, sda: ackb_q};
                            end else begin
                                bit_q  <= bit_q - BIT_W'(1);
                                line_q <= '{scl: 1'b1, sda: 1'b1};
                            end
                        end
                    end
                    ST_RACK: begin
                        case (sub_q)
                            2'd0: begin
                                sub_q      <= 2'd1;
                                line_q.scl <= 1'b1;
                            end
                            2'd1: begin
                                sub_q      <= 2'd2;
                                line_q.scl <= 1'b0;
                            end
                            default: begin
                                sub_q   <= 2'd0;
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        endcase
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign cmd_ready_o = (state_q == ST_IDLE);
    assign accept_o    = accept;
    assign busy_o      = (state_q != ST_IDLE);
    assign len_o       = len_q;
    assign lines_o     = line_q;
    assign rd_data_o   = rsh_q;
    assign ack_err_o   = err_q;
    assign done_o      = done_q;

    // R2
    line_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_q) |-> $past(phase_end_i || accept));

    // R6
    sda_steady_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (line_q.scl && $past(line_q.scl) && !$stable(line_q.sda)) |-> $past(state_q == ST_COND));

    // R10
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == ST_IDLE));

    // R11
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (cmd_i > 3'd4)) |=> ($stable(line_q) && done_q && (state_q == ST_IDLE)));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TICKS_SLOW  = 10,
    parameter int TICKS_FAST  = 3,
    parameter int TICKS_FPLUS = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [2:0]        cmd_i,
    input  logic [1:0]        speed_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_ack_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ack_err_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              sda_i
);
    localparam int CNT_W = $clog2(TICKS_SLOW + 1);

    logic             sda_s;
    logic             phase_end;
    logic             accept;
    logic             busy;
    logic [CNT_W-1:0] len;
    lines_t           lines;

    i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sda_i),
        .q_o (sda_s)
    );

    i2c_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (accept),
        .busy_i      (busy),
        .tick_i      (tick_i),
        .len_i       (len),
        .phase_end_o (phase_end)
    );

    i2c_seq #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .TICKS_SLOW  (TICKS_SLOW),
        .TICKS_FAST  (TICKS_FAST),
        .TICKS_FPLUS (TICKS_FPLUS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_ready_o (cmd_ready_o),
        .cmd_i       (cmd_i),
        .speed_i     (speed_i),
        .wr_data_i   (wr_data_i),
        .rd_ack_i    (rd_ack_i),
        .sda_s_i     (sda_s),
        .phase_end_i (phase_end),
        .accept_o    (accept),
        .busy_o      (busy),
        .len_o       (len),
        .lines_o     (lines),
        .rd_data_o   (rd_data_o),
        .ack_err_o   (ack_err_o),
        .done_o      (done_o)
    );

    assign scl_oe_o = ~lines.scl;
    assign sda_oe_o = ~lines.sda;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready_o && $past(rst)) |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [1:0] speed = 2'd0;
    logic [7:0] wr = 8'h00;
    logic       rack = 1'b0;
    logic       ready, done, ack_err, scl_oe, sda_oe;
    logic [7:0] rd;
    logic       scl_bus, sda_bus;

    logic [1:0] div = 2'd0;
    logic       tick;
    always @(posedge clk) div <= div + 2'd1;
    assign tick = (div == 2'd0);

    logic slv_drive = 1'b0;
    assign scl_bus = !scl_oe;
    assign sda_bus = !(sda_oe || slv_drive);

    i2c_byte_engine dut_i (
        .clk (clk), .rst (rst), .tick_i (tick),
        .cmd_valid_i (valid), .cmd_ready_o (ready), .cmd_i (cmd),
        .speed_i (speed), .wr_data_i (wr), .rd_ack_i (rack),
        .done_o (done), .rd_data_o (rd), .ack_err_o (ack_err),
        .scl_oe_o (scl_oe), .sda_oe_o (sda_oe), .sda_i (sda_bus)
    );

    // tick counting between accept and done
    logic cnt_clr = 1'b0, cnt_en = 1'b0;
    int   tick_cnt = 0;
    always @(posedge clk) begin
        if (cnt_clr)     tick_cnt <= 0;
        else if (cnt_en) tick_cnt <= tick_cnt + (tick ? 1 : 0);
    end

    int hcnt = 0;
    always @(posedge clk) begin
        if (scl_bus) hcnt <= hcnt + (tick ? 1 : 0);
        else         hcnt <= 0;
    end

    // slave model and bus monitor
    int       slv_mode = 0;
    int       setup_id = 0;
    logic     slv_ack = 1'b0;
    logic [7:0] slv_tx = 8'h00;
    logic     chk_hi = 1'b0;
    int       exp_n = 10;

    int       mon_setup = 0;
    int       slv_bits = 0;
    logic [7:0] slv_rx = 8'h00;
    logic     mst_ack = 1'b1;
    int       start_cnt = 0, stop_cnt = 0;
    int       mon_checks = 0, mon_fails = 0;
    logic     prv_scl = 1'b1, prv_sda = 1'b1;

    always @(negedge clk) begin
        logic cs, cd;
        cs = scl_bus;
        cd = sda_bus;
        if (cs && prv_scl) begin
            if (prv_sda && !cd) start_cnt++;
            if (!prv_sda && cd) stop_cnt++;
            if (slv_mode != 0 && cd != prv_sda) begin
                mon_checks++;
                mon_fails++;
                $display("FAIL R6 data changed with clock high: actual=%0b expected=%0b", cd, prv_sda);
            end
        end
        if (!prv_scl && cs) begin
            if (slv_mode == 1 && slv_bits < 8) slv_rx = {slv_rx[6:0], cd};
            if (slv_mode == 2 && slv_bits == 8) mst_ack = cd;
        end
        if (prv_scl && !cs) begin
            if (chk_hi) begin
                mon_checks++;
                if (hcnt != exp_n) begin
                    mon_fails++;
                    $display("FAIL R2 clock high width: actual=%0d expected=%0d", hcnt, exp_n);
                end
            end
            slv_bits++;
            if (slv_mode == 1) slv_drive = (slv_bits == 8) && slv_ack;
            if (slv_mode == 2) slv_drive = (slv_bits < 8) ? !slv_tx[7 - slv_bits] : 1'b0;
        end
        if (setup_id != mon_setup) begin
            mon_setup = setup_id;
            slv_bits  = 0;
            slv_drive = (slv_mode == 2) ? !slv_tx[7] : 1'b0;
        end
        prv_scl = cs;
        prv_sda = cd;
    end

    int checks = 0, fails = 0;
    int last_ticks = 0;
    logic busy_seen = 1'b0, ready_at_done = 1'b0;
    logic timed_out = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic slave_cfg(input int mode, input logic ackv, input logic [7:0] tx);
        @(posedge clk); #2;
        slv_mode = mode;
        slv_ack  = ackv;
        slv_tx   = tx;
        setup_id++;
        @(posedge clk); #2;
    endtask

    task automatic issue(input logic [2:0] c, input logic [7:0] wd, input logic ra,
                         input bit chg, input logic [1:0] new_speed);
        @(posedge clk); #2;
        while (!ready) begin @(posedge clk); #2; end
        cmd = c; wr = wd; rack = ra; valid = 1'b1; cnt_clr = 1'b1;
        @(posedge clk); #2;
        valid = 1'b0; cnt_clr = 1'b0; cnt_en = 1'b1;
        busy_seen = !ready;
        if (chg) speed = new_speed;
        while (!done) begin @(posedge clk); #2; end
        cnt_en = 1'b0;
        last_ticks = tick_cnt;
        ready_at_done = ready;
        @(posedge clk); #2;
        chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
    endtask

    function automatic int ticks_for(input logic [1:0] s);
        return (s == 2'd0) ? 10 : (s == 2'd1) ? 3 : 1;
    endfunction

    task automatic run_all();
        int n, st0, sp0;
        logic [7:0] pat;
        repeat (3) @(posedge clk);
        #2;
        chk(scl_oe == 0, "R1", "scl_oe in reset", scl_oe, 0);
        chk(sda_oe == 0, "R1", "sda_oe in reset", sda_oe, 0);
        @(posedge clk); rst = 1'b0; #2;
        chk(ready == 1, "R1", "ready after reset", ready, 1);
        chk(done == 0, "R1", "done after reset", done, 0);

        for (int s = 0; s < 4; s++) begin
            speed = 2'(s);
            n = ticks_for(2'(s));
            exp_n = n;
            st0 = start_cnt; sp0 = stop_cnt;
            issue(3'd0, 8'h00, 1'b0, 1'b0, 2'd0);
            chk(last_ticks == 3 * n, "R2", "start ticks", last_ticks, 3 * n);
            chk(start_cnt == st0 + 1, "R3", "start conditions", start_cnt, st0 + 1);
            chk({scl_bus, sda_bus} == 2'b00, "R3", "wires after start", {scl_bus, sda_bus}, 0);
            chk(busy_seen, "R10", "ready low while busy", busy_seen, 1);
            chk(ack_err == 0, "R10", "ack_err after start", ack_err, 0);

            for (int i = 0; i < 4; i++) begin
                case (i)
                    0: pat = 8'hA5;
                    1: pat = 8'h00;
                    2: pat = 8'hFF;
                    default: pat = 8'h3C;
                endcase
                pat = pat ^ 8'(s * 17);
                slave_cfg(1, (i % 2) == 0, 8'h00);
                chk_hi = 1'b1;
                issue(3'd3, pat, 1'b0, 1'b0, 2'd0);
                chk_hi = 1'b0;
                slv_mode = 0;
                chk(slv_rx == pat, "R6", "byte seen by slave", slv_rx, pat);
                chk(ack_err == !((i % 2) == 0), "R7", "ack_err", ack_err, !((i % 2) == 0));
                chk(last_ticks == 27 * n, "R7", "write ticks", last_ticks, 27 * n);
                chk(ready_at_done == 1, "R10", "ready at done", ready_at_done, 1);
            end

            st0 = start_cnt; sp0 = stop_cnt;
            issue(3'd1, 8'h00, 1'b0, 1'b0, 2'd0);
            chk(last_ticks == 4 * n, "R4", "repeated start ticks", last_ticks, 4 * n);
            chk(start_cnt == st0 + 1, "R4", "start conditions", start_cnt, st0 + 1);
            chk(stop_cnt == sp0, "R4", "no stop", stop_cnt, sp0);
            chk({scl_bus, sda_bus} == 2'b00, "R4", "wires after repeated start", {scl_bus, sda_bus}, 0);

            for (int i = 0; i < 2; i++) begin
                pat = (i == 0) ? (8'h5A ^ 8'(s)) : 8'h81;
                slave_cfg(2, 1'b0, pat);
                chk_hi = 1'b1;
                issue(3'd4, 8'h00, 1'(i), 1'b0, 2'd0);
                chk_hi = 1'b0;
                slv_mode = 0;
                chk(rd == pat, "R8", "received byte", rd, pat);
                chk(mst_ack == 1'(i), "R9", "acknowledge bit sent", mst_ack, i);
                chk(last_ticks == 20 * n, "R9", "read ticks", last_ticks, 20 * n);
                chk(ack_err == 0, "R10", "ack_err after read", ack_err, 0);
            end

            sp0 = stop_cnt;
            issue(3'd2, 8'h00, 1'b0, 1'b0, 2'd0);
            chk(last_ticks == 3 * n, "R5", "stop ticks", last_ticks, 3 * n);
            chk(stop_cnt == sp0 + 1, "R5", "stop conditions", stop_cnt, sp0 + 1);
            chk({scl_bus, sda_bus} == 2'b11, "R5", "wires after stop", {scl_bus, sda_bus}, 3);

            issue(3'(5 + (s % 3)), 8'h00, 1'b0, 1'b0, 2'd0);
            chk(last_ticks == 0, "R11", "reserved ticks", last_ticks, 0);
            chk(!busy_seen, "R11", "reserved done next cycle", busy_seen, 0);
            chk({scl_bus, sda_bus} == 2'b11, "R11", "wires unchanged", {scl_bus, sda_bus}, 3);
        end

        // speed captured at accept
        speed = 2'd0;
        exp_n = 10;
        issue(3'd0, 8'h00, 1'b0, 1'b0, 2'd0);
        slave_cfg(1, 1'b1, 8'h00);
        chk_hi = 1'b1;
        issue(3'd3, 8'h96, 1'b0, 1'b1, 2'd2);
        chk_hi = 1'b0;
        slv_mode = 0;
        chk(last_ticks == 270, "R2", "speed held during command", last_ticks, 270);
        chk(slv_rx == 8'h96, "R6", "byte with speed change", slv_rx, 8'h96);
        exp_n = 1;
        issue(3'd2, 8'h00, 1'b0, 1'b0, 2'd0);
        chk(last_ticks == 3, "R2", "new speed on next command", last_ticks, 3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            fails++;
            checks++;
            $display("FAIL R10 watchdog expired: actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end
endmodule